// File: doc/BRIEF.md
# Supply fault latch and on/off sequencer

This block is the digital control core of a supply supervisor. Comparators outside the block raise flags when one of three rails is too high or one of two lower rails is too low. An active-low run request from the host board turns the main rails on and off. A timebase tick paces every duration. The block deglitches each fault flag and debounces the run request. It sequences turn-on and turn-off. A qualified fault sets a sticky latch that forces the main rails off.

The output `fault_off` is high when the main rails must carry no current. `fault_held` reports the latched fault to the power-good logic, which pulls power-good low while it is set. Turn-on takes effect as soon as the request has been debounced. Turn-off waits a further programmable delay. Under-voltage detection is blanked for a fixed time after each turn-on, so that a rail still ramping up is not reported as a fault. The latch is released only when a debounced turn-off completes, or by the power-on reset.

Top module: `supply_guard`

## Requirements
- R1: A high-voltage flag on any rail, `ov_flag` bits 0 to 2, that stays high for OV_TICKS consecutive ticks while the rails are on sets the fault latch on the tick that completes the window. A flag that stays high for one tick fewer leaves the latch clear.
- R2: A low-voltage flag on either rail, `uv_flag` bits 0 and 1, that stays high for UV_TICKS consecutive ticks sets the fault latch once blanking has ended. One tick fewer leaves the latch clear.
- R3: A flag that drops before its window is complete restarts its count from zero. Two partial runs with a gap between them never add up to a fault.
- R4: While the latch is set, `fault_held` and `fault_off` are both high. The latch stays set whatever the flags do, until a debounced turn-off completes its delay.
- R5: The run request passes through a two-flop synchronizer. A new level must then persist for DEB_TICKS ticks before it is acted on. Shorter pulses in either direction change nothing.
- R6: After a debounced turn-off, `fault_off` rises OFF_TICKS ticks later. That is DEB_TICKS+3+OFF_TICKS clock edges after `run_n` rises, with a tick on every cycle.
- R7: After a debounced turn-on, `fault_off` falls on the next edge with no added delay. That is DEB_TICKS+3 edges after `run_n` falls, unless a fault is latched.
- R8: Low-voltage flags are ignored for BLANK_TICKS ticks after each debounced turn-on. A flag held through blanking latches UV_TICKS ticks after blanking ends.
- R9: While the rails are off, `fault_off` is high and no flag can set the latch.
- R10: After reset, `fault_off` is 1 and `fault_held` is 0. The request is taken as "off".
- R11: All windows advance only on cycles where `tick` is high. A flag held while `tick` is low never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| ov_flag | input | OV_RAILS | Per-rail high-voltage comparator flags |
| uv_flag | input | UV_RAILS | Per-rail low-voltage comparator flags |
| run_n | input | 1 | Active-low run request, asynchronous |
| fault_off | output | 1 | High: main rails must be off |
| fault_held | output | 1 | High: a fault is latched |

## Verification
Two functions can fall on the same clock edge: a high-voltage fault finishing its window, and the debounced turn-off moving the sequencer into its stopping phase. The bench raises the flag so that its last counted tick lands exactly on the edge where the turn-off takes effect. It then checks that the latch is set, that `fault_off` never drops during the turn-off delay, and that the latch clears exactly when the delay ends. Other window edges are exercised by holding flags one tick short of, and exactly at, their windows.

// File: rtl/supguard_pkg.sv
package supguard_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_ON   = 2'd1,
    SEQ_STOP = 2'd2
  } seq_state_t;

  // bits needed to hold 0..limit
  function automatic int width_for(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/supguard_sync2.sv
module supguard_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/supguard_debounce.sv
module supguard_debounce
  import supguard_pkg::*;
#(
  parameter int DEB_TICKS = 38000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level_in,
  output logic rise_p,
  output logic fall_p
);
  localparam int CW = width_for(DEB_TICKS);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic          stable_q;
  logic [CW-1:0] cnt_q;
  logic          differ;
  logic          flip;

  assign differ = level_in != stable_q;
  assign flip   = differ & tick & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b1;
      cnt_q    <= '0;
      rise_p   <= 1'b0;
      fall_p   <= 1'b0;
    end else begin
      rise_p <= flip & level_in;
      fall_p <= flip & ~level_in;
      if (!differ) begin
        cnt_q <= '0;
      end else if (flip) begin
        stable_q <= level_in;
        cnt_q    <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R5: agreement with the settled level restarts the window
  a_r5_match_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!differ) |=> (cnt_q == '0));
  // R5: an event pulse always reports the level now settled
  a_r5_rise_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |-> stable_q);
  a_r5_fall_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    fall_p |-> !stable_q);
endmodule

// File: rtl/supguard_deglitch.sv
module supguard_deglitch
  import supguard_pkg::*;
#(
  parameter int WIN_TICKS = 73
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flag,
  input  logic en,
  output logic qual
);
  localparam int CW = width_for(WIN_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          armed;

  assign armed = flag & en;
  // the tick that completes the window qualifies the fault
  assign qual  = armed & tick & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!armed)                 cnt_q <= '0;
    else if (tick && cnt_q != LAST)  cnt_q <= cnt_q + CW'(1);
  end

  // R3: a dropped or disabled flag forgets its partial count
  a_r3_restart_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |=> (cnt_q == '0));
  // R11: no progress without a tick
  a_r11_idle_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/supguard_rail_bank.sv
module supguard_rail_bank #(
  parameter int RAILS     = 3,
  parameter int WIN_TICKS = 73
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [RAILS-1:0] flags,
  input  logic             en,
  output logic             hit
);
  logic [RAILS-1:0] qual_v;

  for (genvar g = 0; g < RAILS; g++) begin : g_rail
    supguard_deglitch #(.WIN_TICKS(WIN_TICKS)) u_dg (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .flag (flags[g]),
      .en   (en),
      .qual (qual_v[g])
    );
  end

  assign hit = |qual_v;
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supguard_pkg::*;
#(
  parameter int OV_RAILS    = 3,
  parameter int UV_RAILS    = 2,
  parameter int OV_TICKS    = 73,
  parameter int UV_TICKS    = 146,
  parameter int DEB_TICKS   = 38000,
  parameter int OFF_TICKS   = 2300,
  parameter int BLANK_TICKS = 75000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [OV_RAILS-1:0] ov_flag,
  input  logic [UV_RAILS-1:0] uv_flag,
  input  logic                run_n,
  output logic                fault_off,
  output logic                fault_held
);
  localparam int BW = width_for(BLANK_TICKS);
  localparam int SW = width_for(OFF_TICKS);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_TICKS);
  localparam logic [SW-1:0] STOP_LAST = SW'(OFF_TICKS - 1);

  // named internal events
  logic run_sync, start_evt, stop_evt;
  logic ov_en, uv_en, ov_hit, uv_hit, fault_hit;
  logic blank_done, stop_done;

  seq_state_t    st_q;
  logic [BW-1:0] blank_q;
  logic [SW-1:0] stop_q;
  logic          latch_q;

  supguard_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(run_n), .q_sync(run_sync)
  );

  supguard_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level_in(run_sync),
    .rise_p(stop_evt), .fall_p(start_evt)
  );

  assign blank_done = (blank_q == BLANK_END);
  assign ov_en      = (st_q == SEQ_ON);
  assign uv_en      = ov_en & blank_done;
  assign stop_done  = (st_q == SEQ_STOP) & tick & (stop_q == STOP_LAST);

  supguard_rail_bank #(.RAILS(OV_RAILS), .WIN_TICKS(OV_TICKS)) u_ov (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flags(ov_flag), .en(ov_en), .hit(ov_hit)
  );

  supguard_rail_bank #(.RAILS(UV_RAILS), .WIN_TICKS(UV_TICKS)) u_uv (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flags(uv_flag), .en(uv_en), .hit(uv_hit)
  );

  assign fault_hit = ov_hit | uv_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_OFF;
      blank_q <= '0;
      stop_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      if (fault_hit)      latch_q <= 1'b1;
      else if (stop_done) latch_q <= 1'b0;

      case (st_q)
        SEQ_OFF: begin
          if (start_evt) begin
            st_q    <= SEQ_ON;
            blank_q <= '0;
          end
        end
        SEQ_ON: begin
          if (tick && !blank_done) blank_q <= blank_q + BW'(1);
          if (stop_evt) begin
            st_q   <= SEQ_STOP;
            stop_q <= '0;
          end
        end
        SEQ_STOP: begin
          if (start_evt) begin
            st_q    <= SEQ_ON;
            blank_q <= '0;
          end else if (stop_done) begin
            st_q <= SEQ_OFF;
          end else if (tick) begin
            stop_q <= stop_q + SW'(1);
          end
        end
        default: st_q <= SEQ_OFF;
      endcase
    end
  end

  assign fault_off  = latch_q | (st_q == SEQ_OFF);
  assign fault_held = latch_q;

  // R4: a latched fault always holds the rails off
  a_r4_held_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_held |-> fault_off);
  // R4: only a finished turn-off releases the latch
  a_r4_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !stop_done) |=> latch_q);
  // R9: no fault can be taken while the rails are not on
  a_r9_no_set_unless_on: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SEQ_ON && !latch_q) |=> !latch_q);
  // R8: blanking is in force on the first cycle of every turn-on
  a_r8_blank_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == SEQ_ON) |-> !uv_en);
  // R7: a debounced turn-on acts on the very next edge
  a_r7_on_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && st_q == SEQ_OFF) |=> (st_q == SEQ_ON));
  // R6: the stop phase holds until its delay completes
  a_r6_stop_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_STOP && !stop_done && !start_evt) |=> (st_q == SEQ_STOP));
endmodule

// File: tb/supply_guard_tb.sv
module supply_guard_tb;
  localparam int OVT = 3;
  localparam int UVT = 5;
  localparam int DEB = 6;
  localparam int OFT = 4;
  localparam int BLK = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [2:0] ov_flag = '0;
  logic [1:0] uv_flag = '0;
  logic       run_n = 1'b1;
  logic       fault_off, fault_held;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supply_guard #(
    .OV_TICKS(OVT), .UV_TICKS(UVT), .DEB_TICKS(DEB),
    .OFF_TICKS(OFT), .BLANK_TICKS(BLK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ov_flag(ov_flag),
    .uv_flag(uv_flag), .run_n(run_n), .fault_off(fault_off), .fault_held(fault_held)
  );

  // kind (0 high-voltage, 1 low-voltage), rail, ticks held, latch expected
  localparam int VEC [6][4] = '{
    '{0, 0, 3, 1},
    '{0, 1, 2, 0},
    '{0, 2, 3, 1},
    '{1, 0, 5, 1},
    '{1, 1, 4, 0},
    '{1, 1, 5, 1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic go_on();
    run_n = 1'b0;
    step(DEB + 3 + BLK);
  endtask

  task automatic go_off();
    run_n = 1'b1;
    step(DEB + 3 + OFT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R10 reset fault_off", fault_off, 1'b1);
    chk("R10 reset fault_held", fault_held, 1'b0);

    // turn-on timing
    run_n = 1'b0;
    step(DEB + 2);
    chk("R7 still off one edge before", fault_off, 1'b1);
    step(1);
    chk("R7 on without added delay", fault_off, 1'b0);
    step(BLK);

    // windows: R1 rows (kind 0) and R2 rows (kind 1)
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][0] == 0) ov_flag[VEC[v][1]] = 1'b1;
      else                uv_flag[VEC[v][1]] = 1'b1;
      step(VEC[v][2]);
      ov_flag = '0;
      uv_flag = '0;
      step(2);
      chk(VEC[v][0] == 0 ? "R1 window" : "R2 window", fault_held, VEC[v][3] != 0);
      chk(VEC[v][0] == 0 ? "R1 output" : "R2 output", fault_off, VEC[v][3] != 0);
      if (VEC[v][3] != 0) begin
        go_off();
        go_on();
      end
    end

    // R3: two partial runs do not add up
    ov_flag[0] = 1'b1; step(2);
    ov_flag[0] = 1'b0; step(1);
    ov_flag[0] = 1'b1; step(2);
    ov_flag[0] = 1'b0; step(2);
    chk("R3 restart after drop", fault_held, 1'b0);

    // R11: no ticks, no progress
    tick = 1'b0;
    ov_flag[1] = 1'b1;
    step(10);
    chk("R11 held without tick", fault_held, 1'b0);
    tick = 1'b1;
    step(OVT);
    chk("R11 qualifies once ticking", fault_held, 1'b1);
    ov_flag = '0;
    step(20);
    chk("R4 latch sticky", fault_held, 1'b1);
    chk("R4 rails held off", fault_off, 1'b1);
    go_off();
    chk("R4 released by turn-off", fault_held, 1'b0);

    // R9: flags ignored while off
    ov_flag = 3'b111;
    uv_flag = 2'b11;
    step(12);
    chk("R9 off ignores flags", fault_held, 1'b0);
    chk("R9 off output", fault_off, 1'b1);
    ov_flag = '0;
    uv_flag = '0;

    // R5: short low pulse while off is ignored
    run_n = 1'b0; step(3);
    run_n = 1'b1; step(DEB + 10);
    chk("R5 short on-pulse ignored", fault_off, 1'b1);

    // R8: low-voltage flag held through blanking
    uv_flag[0] = 1'b1;
    run_n = 1'b0;
    step(DEB + 2 + BLK + UVT);
    chk("R8 blanked window", fault_held, 1'b0);
    step(1);
    chk("R8 latches after blanking", fault_held, 1'b1);
    uv_flag = '0;
    go_off();
    chk("R8 cleared by turn-off", fault_held, 1'b0);
    go_on();
    chk("R9 nothing latched while off", fault_off, 1'b0);

    // R5: short high pulse while on is ignored
    run_n = 1'b1; step(3);
    run_n = 1'b0; step(DEB + OFT + 10);
    chk("R5 short off-pulse ignored", fault_off, 1'b0);

    // R6: exact turn-off delay
    run_n = 1'b1;
    step(DEB + 2 + OFT);
    chk("R6 still on one edge before", fault_off, 1'b0);
    step(1);
    chk("R6 off after delay", fault_off, 1'b1);
    go_on();

    // same edge: fault completes as the turn-off takes effect
    run_n = 1'b1;
    step(DEB + 3 - OVT);
    ov_flag[2] = 1'b1;
    step(OVT);
    ov_flag = '0;
    chk("R1 latch on turn-off edge", fault_held, 1'b1);
    chk("R4 rails off at once", fault_off, 1'b1);
    step(OFT - 1);
    chk("R4 still latched in delay", fault_held, 1'b1);
    chk("R4 no gap in delay", fault_off, 1'b1);
    step(1);
    chk("R6 latch released at delay end", fault_held, 1'b0);
    chk("R6 off after release", fault_off, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule